// File: doc/BRIEF.md
# Real-Time Clock Register Front End

This block sits between a simple single-cycle register bus and the calendar core of a real-time clock. It decodes a word-aligned byte register map covering the live time fields, the alarm fields, control, status, interrupt enables, oscillator enable, two key registers and a wake enable. Time fields are owned by the core. The front end reads them back from a packed input vector. A write to a time field sends a one-cycle load strobe and the byte toward the core. Alarm fields are stored here and presented to the core as a packed vector.

The core reports second, minute, hour, day and alarm events as single-cycle pulses. The front end keeps each event as a sticky status flag that software clears by writing a one to it. A power-up flag is set by reset. Busy and running are shown live from the core. Each interrupt line is a sticky flag ANDed with its enable bit. Every write except a key write is refused until software writes two magic words to the key registers in order. Writing zero to the first key locks the block again. Reads are always allowed.

Top module: `rtc_regfront`

## Requirements
- R1: After reset the block is locked. Key 0 (0x6C) reads 0 and status (0x44) reads 0x80, with only the power-up flag (bit 7) set and bits 1:0 following the core's live inputs. Control, interrupt enable, oscillator, wake and the alarm fields all read 0. All interrupt and wake outputs are low.
- R2: The block unlocks only in this order: a write of 0x83E70B13 to key 0 (0x6C), then a write of 0x95A4F1E0 to key 1 (0x70). A key 1 write with any other value after the first key returns the block to locked. While unlocked, key 0 reads back 1 in bit 0.
- R3: A write of 0 to key 0 locks the block from any state. After that, key 0 reads 0 and other register writes are refused again.
- R4: While locked, every bus write other than a write to the key registers has no effect. No time load strobe fires. Control, enables and alarm fields keep their values. Status flags are not cleared.
- R5: An unlocked write to time field i, at offset 4*i for i in 0..6, raises only bit i of `time_ld` for the cycle of the write, with `ld_byte` equal to write data bits 7:0. A read of offset 4*i returns byte i of `core_time`.
- R6: Alarm field j, for j in 0..5, sits at offset 0x20+4*j. It takes bits 7:0 of an unlocked write, reads back at that offset, and appears on `alarm_val[8*j+7:8*j]`.
- R7: Control (0x40) stores bits 0, 2, 3, 5, 6 and 7 and drives them on `ctl_bits`. Bits 1 and 4 stay 0. On a read, bit 7 (split power) always returns 0 even when it is stored.
- R8: Status bits 2..6 are sticky flags, in this order: second, minute, hour, day, alarm. Each is set by a pulse on its event input. Bits 2..7 are cleared by an unlocked status write with a 1 in that bit. When an event and a clear of the same flag arrive in the same cycle, the event wins.
- R9: Status bit 0 shows `core_busy` and bit 1 shows `core_running` live. Neither is stored.
- R10: Interrupt enable (0x48) bit 3 gates the alarm flag onto `irq_alarm`, and bit 2 gates the second flag onto `irq_timer`. Writing 0 to it drops both lines.
- R11: Oscillator register (0x54) bit 6 drives `osc_en`. Wake enable (0x7C) bit 1 gates the alarm flag onto `wake_alarm`.
- R12: Reads of any register return current contents whether the block is locked or unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data (keys use all 32 bits, others bits 7:0) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_time | input | 56 | Seven time bytes from the core, field i in bits 8*i+7:8*i |
| core_busy | input | 1 | Core busy, live |
| core_running | input | 1 | Core running, live |
| evt_sec | input | 1 | One-second event pulse |
| evt_min | input | 1 | One-minute event pulse |
| evt_hour | input | 1 | One-hour event pulse |
| evt_day | input | 1 | One-day event pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| time_ld | output | 7 | Per-field load strobe toward the core |
| ld_byte | output | 8 | Byte to load with `time_ld` |
| alarm_val | output | 48 | Six alarm bytes toward the core |
| ctl_bits | output | 8 | Stored control bits |
| osc_en | output | 1 | Functional clock enable |
| irq_timer | output | 1 | Periodic timer interrupt |
| irq_alarm | output | 1 | Alarm interrupt |
| wake_alarm | output | 1 | Alarm wake-up request |

## Verification
The assertions assume each event input is a single-cycle pulse sampled at the rising edge. They also assume bus accesses last exactly one cycle with address and data held across that edge. The bench drives every bus access and every event pulse from the falling edge and releases them one cycle later, so each is seen by exactly one rising edge. It samples the combinational outputs one nanosecond after driving. The only same-cycle collision it creates on purpose is the event-against-clear case, and the set-wins property covers that case.

// File: rtl/rtcf_pkg.sv
package rtcf_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int FLD_W  = 8;
  localparam int N_FLAG = 6;

  typedef enum logic [1:0] {KS_SHUT = 2'd0, KS_HALF = 2'd1, KS_OPEN = 2'd2} key_st_e;

  localparam logic [ADDR_W-1:0] OFS_TIME_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ALM_BASE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTL       = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_STS       = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_IEN       = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_OSC       = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_KEY0      = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_KEY1      = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_WAKE      = 8'h7C;

  localparam logic [FLD_W-1:0] CTL_WMASK  = 8'hED;
  localparam logic [FLD_W-1:0] CTL_RMASK  = 8'h6D;
  localparam logic [FLD_W-1:0] IEN_WMASK  = 8'h0C;
  localparam logic [FLD_W-1:0] OSC_WMASK  = 8'h40;
  localparam logic [FLD_W-1:0] WAKE_WMASK = 8'h02;

  // sticky flag order (status bits 2..7): sec, min, hour, day, alarm, power-up
  localparam int FL_SEC = 0;
  localparam int FL_ALM = 4;
  localparam int FL_PWR = 5;
  localparam logic [N_FLAG-1:0] FLAG_RST = 6'b100000;

  function automatic logic [ADDR_W-1:0] field_ofs(int idx, logic [ADDR_W-1:0] base);
    return base + ADDR_W'(idx * 4);
  endfunction

  function automatic logic [N_FLAG-1:0] flag_next(logic [N_FLAG-1:0] cur,
                                                  logic [N_FLAG-1:0] set,
                                                  logic [N_FLAG-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic key_st_e key_next(key_st_e cur, logic hit0, logic hit1,
                                       logic [DATA_W-1:0] d,
                                       logic [DATA_W-1:0] m0,
                                       logic [DATA_W-1:0] m1);
    key_st_e n;
    n = cur;
    if (hit0) begin
      if (d == '0)                n = KS_SHUT;
      else if (d == m0)           n = (cur == KS_OPEN) ? KS_OPEN : KS_HALF;
      else if (cur != KS_OPEN)    n = KS_SHUT;
    end else if (hit1 && cur == KS_HALF) begin
      n = (d == m1) ? KS_OPEN : KS_SHUT;
    end
    return n;
  endfunction
endpackage

// File: rtl/rtcf_keylock.sv
module rtcf_keylock
  import rtcf_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY0 = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1 = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit0,
  input  logic              hit1,
  input  logic [DATA_W-1:0] wdata,
  output logic              open
);
  key_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_SHUT;
    else        st_q <= key_next(st_q, hit0, hit1, wdata, KEY0, KEY1);
  end

  assign open = (st_q == KS_OPEN);
endmodule

// File: rtl/rtcf_flags.sv
module rtcf_flags
  import rtcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] set,
  input  logic [N_FLAG-1:0] clr,
  output logic [N_FLAG-1:0] flags
);
  logic [N_FLAG-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= FLAG_RST;
    else        q <= flag_next(q, set, clr);
  end

  assign flags = q;
endmodule

// File: rtl/rtcf_cfgreg.sv
module rtcf_cfgreg
  import rtcf_pkg::*;
#(
  parameter logic [FLD_W-1:0] WMASK = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FLD_W-1:0] d,
  output logic [FLD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d & WMASK;
  end
endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront
  import rtcf_pkg::*;
#(
  parameter int                N_TIME = 7,
  parameter int                N_ALM  = 6,
  parameter logic [DATA_W-1:0] KEY0   = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1   = 32'h95A4F1E0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [N_TIME*FLD_W-1:0] core_time,
  input  logic                    core_busy,
  input  logic                    core_running,
  input  logic                    evt_sec,
  input  logic                    evt_min,
  input  logic                    evt_hour,
  input  logic                    evt_day,
  input  logic                    evt_alarm,
  output logic [N_TIME-1:0]       time_ld,
  output logic [FLD_W-1:0]        ld_byte,
  output logic [N_ALM*FLD_W-1:0]  alarm_val,
  output logic [FLD_W-1:0]        ctl_bits,
  output logic                    osc_en,
  output logic                    irq_timer,
  output logic                    irq_alarm,
  output logic                    wake_alarm
);
  // named internal events
  logic              wr_go;
  logic              acc_ok;
  logic              unlock_open;
  logic              hit_key0, hit_key1;
  logic              sts_wr;
  logic [N_FLAG-1:0] flag_set, flag_clr, flag_q;
  logic [FLD_W-1:0]  ien_q, osc_q, wake_q;
  logic [FLD_W-1:0]  alm_q [N_ALM];
  logic [FLD_W-1:0]  wbyte;

  assign wr_go    = bus_sel & bus_wr;
  assign hit_key0 = wr_go && (bus_addr == OFS_KEY0);
  assign hit_key1 = wr_go && (bus_addr == OFS_KEY1);
  assign acc_ok   = wr_go & unlock_open;
  assign wbyte    = bus_wdata[FLD_W-1:0];
  assign sts_wr   = acc_ok && (bus_addr == OFS_STS);

  rtcf_keylock #(.KEY0(KEY0), .KEY1(KEY1)) u_lock (
    .clk(clk), .rst_n(rst_n), .hit0(hit_key0), .hit1(hit_key1),
    .wdata(bus_wdata), .open(unlock_open)
  );

  assign flag_set = {1'b0, evt_alarm, evt_day, evt_hour, evt_min, evt_sec};
  assign flag_clr = sts_wr ? wbyte[FLD_W-1:2] : '0;

  rtcf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flag_q)
  );

  rtcf_cfgreg #(.WMASK(CTL_WMASK)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(acc_ok && (bus_addr == OFS_CTL)),
    .d(wbyte), .q(ctl_bits)
  );
  rtcf_cfgreg #(.WMASK(IEN_WMASK)) u_ien (
    .clk(clk), .rst_n(rst_n), .we(acc_ok && (bus_addr == OFS_IEN)),
    .d(wbyte), .q(ien_q)
  );
  rtcf_cfgreg #(.WMASK(OSC_WMASK)) u_osc (
    .clk(clk), .rst_n(rst_n), .we(acc_ok && (bus_addr == OFS_OSC)),
    .d(wbyte), .q(osc_q)
  );
  rtcf_cfgreg #(.WMASK(WAKE_WMASK)) u_wake (
    .clk(clk), .rst_n(rst_n), .we(acc_ok && (bus_addr == OFS_WAKE)),
    .d(wbyte), .q(wake_q)
  );

  for (genvar j = 0; j < N_ALM; j++) begin : g_alm
    rtcf_cfgreg #(.WMASK(8'hFF)) u_alm (
      .clk(clk), .rst_n(rst_n),
      .we(acc_ok && (bus_addr == field_ofs(j, OFS_ALM_BASE))),
      .d(wbyte), .q(alm_q[j])
    );
    assign alarm_val[j*FLD_W +: FLD_W] = alm_q[j];
  end

  for (genvar i = 0; i < N_TIME; i++) begin : g_tld
    assign time_ld[i] = acc_ok && (bus_addr == field_ofs(i, OFS_TIME_BASE));
  end
  assign ld_byte = wbyte;

  assign irq_timer  = flag_q[FL_SEC] & ien_q[2];
  assign irq_alarm  = flag_q[FL_ALM] & ien_q[3];
  assign wake_alarm = flag_q[FL_ALM] & wake_q[1];
  assign osc_en     = osc_q[6];

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_TIME; i++)
      if (bus_addr == field_ofs(i, OFS_TIME_BASE))
        bus_rdata[FLD_W-1:0] = core_time[i*FLD_W +: FLD_W];
    for (int j = 0; j < N_ALM; j++)
      if (bus_addr == field_ofs(j, OFS_ALM_BASE))
        bus_rdata[FLD_W-1:0] = alm_q[j];
    case (bus_addr)
      OFS_CTL:  bus_rdata[FLD_W-1:0] = ctl_bits & CTL_RMASK;
      OFS_STS:  bus_rdata[FLD_W-1:0] = {flag_q, core_running, core_busy};
      OFS_IEN:  bus_rdata[FLD_W-1:0] = ien_q;
      OFS_OSC:  bus_rdata[FLD_W-1:0] = osc_q;
      OFS_WAKE: bus_rdata[FLD_W-1:0] = wake_q;
      OFS_KEY0: bus_rdata[0]         = unlock_open;
      default:  ;
    endcase
  end
endmodule

// File: rtl/rtcf_checker.sv
module rtcf_checker
  import rtcf_pkg::*;
#(
  parameter int                N_TIME = 7,
  parameter logic [DATA_W-1:0] KEY1   = 32'h95A4F1E0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              open,
  input logic [N_TIME-1:0] time_ld,
  input logic [FLD_W-1:0]  ctl_bits,
  input logic [N_FLAG-1:0] flags,
  input logic              evt_alarm,
  input logic              irq_timer,
  input logic              irq_alarm
);
  AST_OPEN_AFTER_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(bus_sel && bus_wr && bus_addr == OFS_KEY1 && bus_wdata == KEY1)); // R2
  AST_LOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !open |-> time_ld == '0); // R4
  AST_LOCKED_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(ctl_bits)); // R4
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(time_ld)); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm |=> flags[FL_ALM]); // R8
  AST_PWR_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_PWR]) |-> $past(open && bus_sel && bus_wr && bus_addr == OFS_STS && bus_wdata[7])); // R8
  AST_TIMER_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timer |-> flags[FL_SEC]); // R10
  AST_ALARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_alarm |-> flags[FL_ALM]); // R10
endmodule

bind rtc_regfront rtcf_checker #(.N_TIME(N_TIME), .KEY1(KEY1)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .open(unlock_open),
  .time_ld(time_ld), .ctl_bits(ctl_bits), .flags(flag_q),
  .evt_alarm(evt_alarm), .irq_timer(irq_timer), .irq_alarm(irq_alarm)
);

// File: tb/test_rtc_regfront.sv
`timescale 1ns/1ps
module test_rtc_regfront;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [55:0] core_time = 56'h66_55_44_33_22_11_09;
  logic        core_busy = 0, core_running = 0;
  logic        evt_sec = 0, evt_min = 0, evt_hour = 0, evt_day = 0, evt_alarm = 0;
  logic [6:0]  time_ld;
  logic [7:0]  ld_byte, ctl_bits;
  logic [47:0] alarm_val;
  logic        osc_en, irq_timer, irq_alarm, wake_alarm;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  rtc_regfront i_rtc_regfront (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic br(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pulse(ref logic e);
    @(negedge clk); e = 1;
    @(negedge clk); e = 0;
  endtask

  task automatic unlock();
    bw(8'h6C, 32'h83E70B13);
    bw(8'h70, 32'h95A4F1E0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    br(8'h6C, d); chk("R1 key0 locked", d, 0);
    br(8'h44, d); chk("R1 status", d, 32'h80);
    br(8'h40, d); chk("R1 control", d, 0);
    br(8'h48, d); chk("R1 ien", d, 0);
    br(8'h20, d); chk("R1 alarm0", d, 0);
    chk("R1 outputs", {irq_timer, irq_alarm, wake_alarm, osc_en, alarm_val}, 0);
  endtask

  task automatic t_locked();
    logic [31:0] d;
    bw(8'h40, 32'hFF); chk("R4 ctl ignored", ctl_bits, 0);
    bw(8'h24, 32'h5A); br(8'h24, d); chk("R4 alarm ignored", d, 0);
    bw(8'h44, 32'h80); br(8'h44, d); chk("R4 status clear ignored", d, 32'h80);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 8'h12;
    #1 chk("R4 no load strobe", time_ld, 0);
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    br(8'h0C, d); chk("R12 read time locked", d, 32'h33);
    br(8'h18, d); chk("R12 read last field", d, 32'h66);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    bw(8'h6C, 32'h83E70B13); bw(8'h70, 32'h12345678);
    br(8'h6C, d); chk("R2 wrong key1 stays locked", d, 0);
    bw(8'h40, 32'h01); chk("R2 write refused after bad key", ctl_bits, 0);
    bw(8'h70, 32'h95A4F1E0);
    br(8'h6C, d); chk("R2 key1 alone locked", d, 0);
    unlock();
    br(8'h6C, d); chk("R2 unlocked", d, 1);
  endtask

  task automatic t_time_load();
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 8'(i*4); bus_wdata = 32'hA0 + i;
      #1 chk("R5 strobe", {time_ld, ld_byte}, {7'(1 << i), 8'(8'hA0 + i)});
      @(negedge clk); bus_sel = 0; bus_wr = 0;
      #1 chk("R5 strobe ends", time_ld, 0);
    end
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    logic [47:0] exp = 0;
    for (int j = 0; j < 6; j++) begin
      bw(8'(8'h20 + j*4), 32'hFFFF_FF00 | (8'h11 * (j + 1)));
      exp[j*8 +: 8] = 8'(8'h11 * (j + 1));
    end
    for (int j = 0; j < 6; j++) begin
      br(8'(8'h20 + j*4), d); chk("R6 alarm readback", d, 8'h11 * (j + 1));
    end
    chk("R6 alarm_val", alarm_val, exp);
  endtask

  task automatic t_control();
    logic [31:0] d;
    bw(8'h40, 32'hFF);
    chk("R7 ctl stored", ctl_bits, 8'hED);
    br(8'h40, d); chk("R7 split reads zero", d, 32'h6D);
  endtask

  task automatic t_status();
    logic [31:0] d;
    pulse(evt_sec); pulse(evt_min); pulse(evt_hour); pulse(evt_day);
    br(8'h44, d); chk("R8 flags set", d, 32'hBC);
    bw(8'h44, 32'h0C); br(8'h44, d); chk("R8 w1c sec/min", d, 32'hB0);
    bw(8'h44, 32'h80); br(8'h44, d); chk("R8 w1c power-up", d, 32'h30);
    @(negedge clk); evt_alarm = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h44; bus_wdata = 32'h40;
    @(negedge clk); evt_alarm = 0; bus_sel = 0; bus_wr = 0;
    br(8'h44, d); chk("R8 event wins over clear", d, 32'h70);
    bw(8'h44, 32'hFF); br(8'h44, d); chk("R8 clear all", d, 0);
  endtask

  task automatic t_live();
    logic [31:0] d;
    core_busy = 1; br(8'h44, d); chk("R9 busy live", d, 32'h01);
    core_busy = 0; core_running = 1; br(8'h44, d); chk("R9 run live", d, 32'h02);
    core_running = 0; br(8'h44, d); chk("R9 not stored", d, 0);
  endtask

  task automatic t_irq();
    bw(8'h48, 32'h04);
    pulse(evt_sec); #1 chk("R10 timer irq", {irq_timer, irq_alarm}, 2'b10);
    pulse(evt_alarm); #1 chk("R10 alarm masked", irq_alarm, 0);
    bw(8'h48, 32'h0C); #1 chk("R10 both on", {irq_timer, irq_alarm}, 2'b11);
    bw(8'h48, 32'h00); #1 chk("R10 zero disables", {irq_timer, irq_alarm}, 2'b00);
    bw(8'h44, 32'hFF);
  endtask

  task automatic t_osc_wake();
    bw(8'h54, 32'h40); chk("R11 osc_en", osc_en, 1);
    bw(8'h7C, 32'h02); pulse(evt_alarm); #1 chk("R11 wake", wake_alarm, 1);
    bw(8'h44, 32'h40); #1 chk("R11 wake clears", wake_alarm, 0);
  endtask

  task automatic t_relock();
    logic [31:0] d;
    bw(8'h6C, 32'h0); br(8'h6C, d); chk("R3 relocked", d, 0);
    bw(8'h40, 32'h00); chk("R3 write refused", ctl_bits, 8'hED);
    pulse(evt_day); bw(8'h44, 32'h20); br(8'h44, d); chk("R3 clear refused", d, 32'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_locked(); t_unlock(); t_time_load(); t_alarm();
    t_control(); t_status(); t_live(); t_irq(); t_osc_wake(); t_relock();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule